// File: doc/BRIEF.md
# Chip Reset Sequencer with Cause Vectoring

This block collects the chip's reset causes and turns any accepted one into a reset sequence. It enters reset at once, with no clock needed. It pulls the shared open-drain reset pin low for a fixed count of system clock cycles, then lets the pin go. After a short, selectable settling window it leaves reset on a clock edge. On that same edge it publishes the start address that software should fetch from, chosen from the cause that took effect.

Five causes exist. They are the reset pin seen low from outside, a power-on pulse, a low-voltage flag, a watchdog expiry and a clock-monitor failure. Three of them count only when their own enable conditions hold. The settling window lets the block tell a pin still held low by outside logic from its own pull-down. A pin found low at the end of the window is treated as an outside reset.

Top module: `rst_seq`

## Requirements
- R1: A high `por_pulse` sets `pin_pull_en` and `core_rst` to 1 at once, before any clock edge. After power-on the published vector is 16'hFFFE.
- R2: Once every cause input is inactive, `pin_pull_en` stays 1 for exactly 128 rising clock edges and falls after the 128th. `core_rst` is still 1 when it falls.
- R3: `lvd_flag` starts a reset only when `lvd_det_en` and `lvd_rst_en` are both 1. Such a reset publishes 16'hFFFE. Otherwise the flag leaves `core_rst` at 0 and the vector unchanged.
- R4: `cm_fail` starts a reset only when `cm_en` is 1 and `self_clk_en` is 0. Such a reset publishes 16'hFFFC. Otherwise the flag is ignored.
- R5: `wdog_timeout` starts a reset only when `wdog_rate` is nonzero. Such a reset publishes 16'hFFFA. With `wdog_rate` equal to 0 it is ignored.
- R6: While the block is out of reset, a low level on `pin_in` starts a sequence, and that sequence publishes 16'hFFFE.
- R7: `core_rst` falls 3 + `ext_sel` rising edges after `pin_pull_en` falls, which gives 3 to 6 cycles. It falls synchronously to `clk`.
- R8: If `pin_in` is still seen low at the end of the window, the vector is 16'hFFFE whatever cause began the sequence.
- R9: Causes met in one sequence are ranked as follows: power-on, low-voltage or outside pin first (16'hFFFE), then clock monitor (16'hFFFC), then watchdog (16'hFFFA).
- R10: `vec_addr` changes only on the edge where `core_rst` falls, and it holds its value between sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pin_in | input | 1 | Level read back from the reset pin |
| por_pulse | input | 1 | Power-on detect, active high |
| lvd_flag | input | 1 | Low-voltage detect flag |
| lvd_det_en | input | 1 | Low-voltage detector enable |
| lvd_rst_en | input | 1 | Low-voltage reset enable |
| wdog_timeout | input | 1 | Watchdog expiry flag |
| wdog_rate | input | 3 | Watchdog rate field; 0 means the watchdog is off |
| cm_fail | input | 1 | Clock-monitor failure flag |
| cm_en | input | 1 | Clock-monitor enable |
| self_clk_en | input | 1 | Self-clock mode enable |
| ext_sel | input | 2 | Extra window length minus 3 |
| pin_pull_en | output | 1 | Pull-down enable for the reset pin |
| core_rst | output | 1 | Internal reset, active high |
| vec_addr | output | 16 | Start address for the cause that took effect |

## Verification
The assertions take three things for granted. First, `ext_sel` stays steady during a sequence. Second, a cause held long enough to be classified lasts at least two clock edges. Third, the outside pin is not held low across the edge where reset ends, because holding it there would re-enter reset with no visible fall of `core_rst`. The bench holds each cause for four edges, changes `ext_sel` only while the block is idle, and in the pin-held case lets the pin go between the sampling edge and the exit edge.

// File: rtl/rst_seq.sv
`timescale 1ns/1ps
module rst_seq #(
  parameter int DRIVE_CYC = 128,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_PWR = 16'hFFFE,
  parameter logic [AW-1:0] VEC_CM  = 16'hFFFC,
  parameter logic [AW-1:0] VEC_WD  = 16'hFFFA
) (
  input  logic          clk,
  input  logic          pin_in,
  input  logic          por_pulse,
  input  logic          lvd_flag,
  input  logic          lvd_det_en,
  input  logic          lvd_rst_en,
  input  logic          wdog_timeout,
  input  logic [2:0]    wdog_rate,
  input  logic          cm_fail,
  input  logic          cm_en,
  input  logic          self_clk_en,
  input  logic [1:0]    ext_sel,
  output logic          pin_pull_en,
  output logic          core_rst,
  output logic [AW-1:0] vec_addr
);
  localparam int LAST_MAX = DRIVE_CYC + 2 + 3;
  localparam int CW = $clog2(LAST_MAX + 1);

  logic          in_rst;
  logic [CW-1:0] cnt;
  logic [2:0]    hit, s1, s2, pend, seen;
  logic          p1, p2, arm, done;
  logic [CW-1:0] last_cnt;

  assign hit[0] = por_pulse | (lvd_flag & lvd_det_en & lvd_rst_en);
  assign hit[1] = cm_fail & cm_en & ~self_clk_en;
  assign hit[2] = wdog_timeout & (|wdog_rate);

  assign arm      = (|hit) | (~pin_in & ~in_rst);
  assign last_cnt = CW'(DRIVE_CYC + 2) + {{(CW-2){1'b0}}, ext_sel};
  assign done     = in_rst & (cnt >= last_cnt);

  always_ff @(posedge clk or posedge arm)
    if (arm) begin
      in_rst <= 1'b1;
      cnt    <= '0;
    end else if (done)
      in_rst <= 1'b0;
    else if (in_rst)
      cnt <= cnt + 1'b1;

  assign pin_pull_en = in_rst & (cnt < CW'(DRIVE_CYC));
  assign core_rst    = in_rst;
  assign seen        = pend | s2;

  always_ff @(posedge clk or posedge por_pulse)
    if (por_pulse) begin
      s1       <= '0;
      s2       <= '0;
      p1       <= 1'b0;
      p2       <= 1'b0;
      pend     <= 3'b001;
      vec_addr <= VEC_PWR;
    end else begin
      s1 <= hit;
      s2 <= s1;
      p1 <= pin_in;
      p2 <= p1;
      if (done) begin
        pend     <= '0;
        vec_addr <= (seen[0] | ~p2) ? VEC_PWR :
                    seen[1]         ? VEC_CM  :
                    seen[2]         ? VEC_WD  : VEC_PWR;
      end else
        pend <= seen;
    end

  p_pull_drop_r2: assert property (@(posedge clk) disable iff (por_pulse)
    $fell(pin_pull_en) |-> core_rst);

  p_release_after_window_r7: assert property (@(posedge clk) disable iff (por_pulse)
    $fell(core_rst) |-> $past(!pin_pull_en, 2));

  p_vec_hold_r10: assert property (@(posedge clk) disable iff (por_pulse)
    !$fell(core_rst) |-> $stable(vec_addr));

  p_vec_legal_r9: assert property (@(posedge clk) disable iff (por_pulse)
    !core_rst |-> (vec_addr == VEC_PWR || vec_addr == VEC_CM || vec_addr == VEC_WD));
endmodule

// File: tb/sim_rst_seq.sv
`timescale 1ns/1ps
module sim_rst_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por, lvd, lvd_den, lvd_ren, wdt, cmf, cme, scme, ext_low;
  logic [2:0] rate;
  logic [1:0] sel;
  logic pull, crst;
  logic [15:0] vec;
  wire pin_in = !(pull || ext_low);

  rst_seq u0 (
    .clk(clk), .pin_in(pin_in), .por_pulse(por), .lvd_flag(lvd),
    .lvd_det_en(lvd_den), .lvd_rst_en(lvd_ren), .wdog_timeout(wdt),
    .wdog_rate(rate), .cm_fail(cmf), .cm_en(cme), .self_clk_en(scme),
    .ext_sel(sel), .pin_pull_en(pull), .core_rst(crst), .vec_addr(vec)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // kind: 0 lvd, 1 clock monitor, 2 watchdog, 3 pin, 4 power-on
  task automatic set_cause(input int kind, input bit gate, input bit on);
    case (kind)
      0: begin lvd = on; lvd_den = 1'b1; lvd_ren = gate; end
      1: begin cmf = on; cme = 1'b1; scme = !gate; end
      2: begin wdt = on; rate = gate ? 3'd5 : 3'd0; end
      3: ext_low = on;
      default: por = on;
    endcase
  endtask

  task automatic wait_release();
    for (int k = 0; k < 400 && crst; k++) @(negedge clk);
  endtask

  // {kind[2:0], gate, expect_reset, expect_vec[15:0]}
  localparam logic [20:0] TAB [8] = '{
    {3'd0, 1'b1, 1'b1, 16'hFFFE},
    {3'd1, 1'b0, 1'b0, 16'hFFFE},
    {3'd1, 1'b1, 1'b1, 16'hFFFC},
    {3'd0, 1'b0, 1'b0, 16'hFFFC},
    {3'd2, 1'b1, 1'b1, 16'hFFFA},
    {3'd2, 1'b0, 1'b0, 16'hFFFA},
    {3'd3, 1'b1, 1'b1, 16'hFFFE},
    {3'd4, 1'b1, 1'b1, 16'hFFFE}
  };

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    por = 1'b1; lvd = 0; lvd_den = 0; lvd_ren = 0; wdt = 0; rate = 0;
    cmf = 0; cme = 0; scme = 0; ext_low = 0; sel = 0;
    #1;
    chk("R1 reset state pull", pull, 1);
    chk("R1 reset state core_rst", crst, 1);
    repeat (3) @(negedge clk);
    por = 1'b0;
    wait_release();
    chk("R1 power-on vector", vec, 16'hFFFE);

    for (int i = 0; i < 8; i++) begin
      int kind, n, m;
      bit gate, exp_rst;
      logic [15:0] exp_vec;
      string tag;
      kind = int'(TAB[i][20:18]);
      gate = TAB[i][17];
      exp_rst = TAB[i][16];
      exp_vec = TAB[i][15:0];
      tag = kind == 0 ? "R3" : kind == 1 ? "R4" : kind == 2 ? "R5" : kind == 3 ? "R6" : "R1";
      sel = 2'(i % 4);
      @(negedge clk);
      set_cause(kind, gate, 1'b1);
      #1;
      if (!exp_rst) begin
        repeat (4) @(negedge clk);
        chk({tag, " masked cause no reset"}, crst, 0);
        set_cause(kind, gate, 1'b0);
        repeat (3) @(negedge clk);
        chk({tag, " masked cause vector held (R10)"}, vec, exp_vec);
      end else begin
        chk({tag, " async entry"}, crst, 1);
        if (kind == 3) set_cause(kind, gate, 1'b0);
        else begin
          repeat (4) @(negedge clk);
          set_cause(kind, gate, 1'b0);
        end
        n = 0;
        do begin @(negedge clk); n++; end while (pull && n < 400);
        chk({tag, " R2 drive length"}, n, 128);
        chk({tag, " R2 still in reset at pin release"}, crst, 1);
        m = 0;
        do begin @(negedge clk); m++; end while (crst && m < 40);
        chk({tag, " R7 window length"}, m, 3 + i % 4);
        chk({tag, " vector"}, vec, exp_vec);
      end
    end

    // R9: clock monitor and watchdog together
    @(negedge clk);
    set_cause(1, 1, 1); set_cause(2, 1, 1);
    repeat (4) @(negedge clk);
    set_cause(1, 1, 0); set_cause(2, 1, 0);
    wait_release();
    chk("R9 monitor over watchdog", vec, 16'hFFFC);

    // R8: watchdog start, pin still held low at the sampling edge
    sel = 2'd3;
    @(negedge clk);
    set_cause(2, 1, 1);
    repeat (4) @(negedge clk);
    set_cause(2, 1, 0);
    ext_low = 1'b1;
    for (int k = 0; k < 400 && pull; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    ext_low = 1'b0;
    chk("R8 still in reset before exit", crst, 1);
    wait_release();
    chk("R8 held pin classed as outside", vec, 16'hFFFE);

    // R9: watchdog alone, then low-voltage with clock monitor
    sel = 2'd0;
    @(negedge clk);
    set_cause(2, 1, 1);
    repeat (4) @(negedge clk);
    set_cause(2, 1, 0);
    wait_release();
    chk("R5 watchdog alone", vec, 16'hFFFA);
    @(negedge clk);
    set_cause(0, 1, 1); set_cause(1, 1, 1);
    repeat (4) @(negedge clk);
    set_cause(0, 1, 0); set_cause(1, 1, 0);
    wait_release();
    chk("R9 low-voltage over monitor", vec, 16'hFFFE);
    repeat (5) @(negedge clk);
    chk("R10 vector held while idle", vec, 16'hFFFE);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule